// File: doc/BRIEF.md
# Configurable Adder/Subtractor Core

This block adds or subtracts two operands of a parameterized word length and returns the result together with an unsigned carry-out and a signed overflow flag. Parameters fixed at elaboration choose how the carry is formed: a plain ripple chain, block lookahead, block carry-select or block carry-bypass. Every choice gives the same results at the ports, so an integrator can trade logic depth against area without touching the surrounding logic.

Two further parameters set the function and the pipelining. The function can be fixed to addition, fixed to subtraction, or chosen on each cycle by a mode input. Subtraction is formed in two's complement: the second operand is inverted and the carry into the lowest bit is forced high. The registers can sit on the operand side, on the result side, or be left out. When they are left out the block is purely combinational. When either is present the latency is one cycle.

The three block-based carry schemes split the word into stages of a configurable size, 4 bits by default. When the word length is not a multiple of the stage size, the final stage is shorter than the others.

Top module: `addsub_core`

## Requirements
- R1: With addition selected, `sum_out` equals (a + b) mod 2^WIDTH. With subtraction selected, it equals (a - b) mod 2^WIDTH. This holds for all four carry schemes (ARCH values ripple, lookahead, select and bypass).
- R2: With addition, `carry_out` is bit WIDTH of the unsigned sum. With subtraction, `carry_out` is 1 exactly when a >= b as unsigned numbers, so it is 0 on a borrow.
- R3: `ovf_out` is 1 exactly when the true two's-complement result of the selected operation lies outside the range -2^(WIDTH-1) .. 2^(WIDTH-1)-1.
- R4: With FUNC set to selectable, `sub_in` = 1 subtracts and `sub_in` = 0 adds.
- R5: With FUNC set to add-only, `sub_in` has no effect and the block always adds. With FUNC set to subtract-only, `sub_in` has no effect and the block always subtracts.
- R6: With PIPE set to none, all outputs follow the inputs in the same cycle, with no clock edge needed.
- R7: With PIPE set to input or output registers, the outputs show the result for the inputs sampled at the most recent rising clock edge. They hold their value between edges.
- R8: Reset is synchronous and active high. After an edge with `rst` = 1, an output-registered core shows `sum_out` = 0, `carry_out` = 0 and `ovf_out` = 0. An input-registered core with selectable function clears its held operands and mode to zero, so its outputs show the same three zeros.
- R9: The block-based schemes use STAGE-bit stages. When WIDTH is not a multiple of STAGE, the last stage holds the remaining bits, and the results still obey R1 to R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional registers |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand |
| sub_in | input | 1 | 1 = subtract, 0 = add; used only when FUNC is selectable |
| sum_out | output | WIDTH | Result modulo 2^WIDTH |
| carry_out | output | 1 | Unsigned carry-out; for subtraction, 1 means no borrow |
| ovf_out | output | 1 | Signed overflow flag |

## Verification
The unsigned carry and the signed overflow are separate functions, and both can be raised in the same cycle. Examples are adding two large negative operands, or subtracting across the sign boundary. The bench provokes these cases with a complete sweep of a 6-bit, 4-bit-stage configuration over every operand pair and both modes. It judges each flag on its own: the carry against plain unsigned arithmetic, and the overflow against a range test on the signed result. A mutation that couples the two flags therefore shows up. The same sweep also makes a mode change coincide with a register capture, and the registered cores are checked at the next edge against the values captured there.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    // Carry formation scheme chosen at elaboration
    typedef enum logic [1:0] {
        ARCH_RIPPLE,
        ARCH_LOOKAHEAD,
        ARCH_SELECT,
        ARCH_BYPASS
    } arch_e;

    // Arithmetic function
    typedef enum logic [1:0] {
        FN_ADD,
        FN_SUB,
        FN_BOTH
    } func_e;

    // Register placement
    typedef enum logic [1:0] {
        PIPE_NONE,
        PIPE_IN,
        PIPE_OUT
    } pipe_e;

    // Status flags carried next to the result
    typedef struct packed {
        logic carry;
        logic ovf;
    } flags_t;

    // Number of carry stages; ripple is a single full-width chain
    function automatic int stage_count(input int w, input int s, input arch_e a);
        if (a == ARCH_RIPPLE) begin
            return 1;
        end
        return (w + s - 1) / s;
    endfunction

    // Lowest bit index of a stage
    function automatic int stage_lo(input int idx, input int s, input arch_e a);
        if (a == ARCH_RIPPLE) begin
            return 0;
        end
        return idx * s;
    endfunction

    // Width of a stage; the top stage takes whatever bits remain
    function automatic int stage_len(input int idx, input int w, input int s, input arch_e a);
        int rest;
        if (a == ARCH_RIPPLE) begin
            return w;
        end
        rest = w - idx * s;
        return (rest < s) ? rest : s;
    endfunction

endpackage

// File: rtl/addsub_prep.sv
module addsub_prep
    import addsub_pkg::*;
#(
    parameter int    WIDTH = 8,
    parameter func_e FUNC  = FN_BOTH
) (
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] b_o,
    output logic             c_o
);

    logic do_sub;

    // The function parameter decides whether the mode pin matters
    always_comb begin
        case (FUNC)
            FN_ADD:  do_sub = 1'b0;
            FN_SUB:  do_sub = 1'b1;
            default: do_sub = sub_i;
        endcase
    end

    // Two's complement: invert the second operand and inject a carry
    assign b_o = b_i ^ {WIDTH{do_sub}};
    assign c_o = do_sub;

endmodule

// File: rtl/addsub_stage.sv
module addsub_stage
    import addsub_pkg::*;
#(
    parameter int    SW   = 4,
    parameter arch_e KIND = ARCH_RIPPLE
) (
    input  logic [SW-1:0] a_i,
    input  logic [SW-1:0] b_i,
    input  logic          c_i,
    output logic [SW-1:0] s_o,
    output logic          c_o
);

    logic [SW-1:0] gen;
    logic [SW-1:0] prop;

    assign gen  = a_i & b_i;
    assign prop = a_i ^ b_i;

    generate
        if (KIND == ARCH_LOOKAHEAD) begin : g_lookahead
            // Each carry is a flat sum of generate/propagate products
            logic [SW:0] c;
            logic        term;
            logic        acc;
            always_comb begin
                c[0] = c_i;
                term = 1'b0;
                acc  = 1'b0;
                for (int i = 0; i < SW; i++) begin
                    acc = 1'b0;
                    for (int j = 0; j < SW; j++) begin
                        if (j <= i) begin
                            term = gen[j];
                            for (int k = 0; k < SW; k++) begin
                                if (k > j && k <= i) begin
                                    term = term & prop[k];
                                end
                            end
                            acc = acc | term;
                        end
                    end
                    term = c_i;
                    for (int k = 0; k < SW; k++) begin
                        if (k <= i) begin
                            term = term & prop[k];
                        end
                    end
                    c[i+1] = acc | term;
                end
            end
            assign s_o = prop ^ c[SW-1:0];
            assign c_o = c[SW];
        end else if (KIND == ARCH_SELECT) begin : g_select
            // Both outcomes are formed ahead; the incoming carry picks one
            logic [SW:0] c_lo;
            logic [SW:0] c_hi;
            always_comb begin
                c_lo[0] = 1'b0;
                c_hi[0] = 1'b1;
                for (int i = 0; i < SW; i++) begin
                    c_lo[i+1] = gen[i] | (prop[i] & c_lo[i]);
                    c_hi[i+1] = gen[i] | (prop[i] & c_hi[i]);
                end
            end
            assign s_o = c_i ? (prop ^ c_hi[SW-1:0]) : (prop ^ c_lo[SW-1:0]);
            assign c_o = c_i ? c_hi[SW] : c_lo[SW];
        end else if (KIND == ARCH_BYPASS) begin : g_bypass
            // A fully propagating stage hands its carry-in straight on
            logic [SW:0] c;
            logic        skip;
            always_comb begin
                c[0] = c_i;
                for (int i = 0; i < SW; i++) begin
                    c[i+1] = gen[i] | (prop[i] & c[i]);
                end
            end
            assign skip = &prop;
            assign s_o  = prop ^ c[SW-1:0];
            assign c_o  = skip ? c_i : c[SW];
        end else begin : g_ripple
            logic [SW:0] c;
            always_comb begin
                c[0] = c_i;
                for (int i = 0; i < SW; i++) begin
                    c[i+1] = gen[i] | (prop[i] & c[i]);
                end
            end
            assign s_o = prop ^ c[SW-1:0];
            assign c_o = c[SW];
        end
    endgenerate

endmodule

// File: rtl/addsub_chain.sv
module addsub_chain
    import addsub_pkg::*;
#(
    parameter int    WIDTH = 8,
    parameter int    STAGE = 4,
    parameter arch_e ARCH  = ARCH_LOOKAHEAD
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             c_i,
    output logic [WIDTH-1:0] s_o,
    output logic             c_o,
    output logic             cm_o
);

    localparam int NST = stage_count(WIDTH, STAGE, ARCH);

    logic [NST:0] link;

    assign link[0] = c_i;

    generate
        for (genvar gi = 0; gi < NST; gi++) begin : g_stage
            localparam int LO  = stage_lo(gi, STAGE, ARCH);
            localparam int LEN = stage_len(gi, WIDTH, STAGE, ARCH);
            addsub_stage #(
                .SW   (LEN),
                .KIND (ARCH)
            ) u_stage (
                .a_i (a_i[LO +: LEN]),
                .b_i (b_i[LO +: LEN]),
                .c_i (link[gi]),
                .s_o (s_o[LO +: LEN]),
                .c_o (link[gi+1])
            );
        end
    endgenerate

    assign c_o  = link[NST];
    // Carry into the top bit, recovered from the top sum bit
    assign cm_o = s_o[WIDTH-1] ^ a_i[WIDTH-1] ^ b_i[WIDTH-1];

endmodule

// File: rtl/addsub_core.sv
module addsub_core
    import addsub_pkg::*;
#(
    parameter int    WIDTH = 8,
    parameter int    STAGE = 4,
    parameter arch_e ARCH  = ARCH_LOOKAHEAD,
    parameter func_e FUNC  = FN_BOTH,
    parameter pipe_e PIPE  = PIPE_NONE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             sub_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out,
    output logic             ovf_out
);

    typedef struct packed {
        logic [WIDTH-1:0] a;
        logic [WIDTH-1:0] b;
        logic             sub;
    } opnd_t;

    typedef struct packed {
        logic [WIDTH-1:0] sum;
        flags_t           fl;
    } res_t;

    opnd_t            op_raw;
    opnd_t            op_use;
    res_t             res_raw;
    res_t             res_use;
    logic [WIDTH-1:0] b_eff;
    logic             c_first;
    logic             c_last;
    logic             c_msb;

    assign op_raw = '{a: a_in, b: b_in, sub: sub_in};

    // Operand-side register
    generate
        if (PIPE == PIPE_IN) begin : g_in_reg
            opnd_t op_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    op_q <= '0;
                end else begin
                    op_q <= op_raw;
                end
            end
            assign op_use = op_q;
        end else begin : g_in_pass
            assign op_use = op_raw;
        end
    endgenerate

    addsub_prep #(
        .WIDTH (WIDTH),
        .FUNC  (FUNC)
    ) u_prep (
        .b_i   (op_use.b),
        .sub_i (op_use.sub),
        .b_o   (b_eff),
        .c_o   (c_first)
    );

    addsub_chain #(
        .WIDTH (WIDTH),
        .STAGE (STAGE),
        .ARCH  (ARCH)
    ) u_chain (
        .a_i  (op_use.a),
        .b_i  (b_eff),
        .c_i  (c_first),
        .s_o  (res_raw.sum),
        .c_o  (c_last),
        .cm_o (c_msb)
    );

    assign res_raw.fl.carry = c_last;
    assign res_raw.fl.ovf   = c_last ^ c_msb;

    // Result-side register
    generate
        if (PIPE == PIPE_OUT) begin : g_out_reg
            res_t res_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    res_q <= '0;
                end else begin
                    res_q <= res_raw;
                end
            end
            assign res_use = res_q;
        end else begin : g_out_pass
            assign res_use = res_raw;
        end
    endgenerate

    assign sum_out   = res_use.sum;
    assign carry_out = res_use.fl.carry;
    assign ovf_out   = res_use.fl.ovf;

    // ------------------------------------------------------------------
    // Arithmetic reference for the assertions, taken straight from the ports
    logic             ref_sub;
    logic [WIDTH-1:0] ref_sum;
    logic [WIDTH:0]   ref_wide;
    logic             ref_carry;
    logic             ref_ovf;

    always_comb begin
        ref_sub   = (FUNC == FN_BOTH) ? sub_in : (FUNC == FN_SUB);
        ref_wide  = {1'b0, a_in} + {1'b0, b_in};
        ref_sum   = ref_sub ? (a_in - b_in) : (a_in + b_in);
        ref_carry = ref_sub ? (a_in >= b_in) : ref_wide[WIDTH];
        if (ref_sub) begin
            ref_ovf = (a_in[WIDTH-1] != b_in[WIDTH-1]) && (ref_sum[WIDTH-1] != a_in[WIDTH-1]);
        end else begin
            ref_ovf = (a_in[WIDTH-1] == b_in[WIDTH-1]) && (ref_sum[WIDTH-1] != a_in[WIDTH-1]);
        end
    end

    generate
        if (PIPE == PIPE_NONE) begin : g_chk_comb
            AST_SUM_MATCH: assert property (@(posedge clk) disable iff (rst)
                sum_out == ref_sum); // R1
            AST_CARRY_MATCH: assert property (@(posedge clk) disable iff (rst)
                carry_out == ref_carry); // R2
            AST_OVF_SIGNED: assert property (@(posedge clk) disable iff (rst)
                ovf_out == ref_ovf); // R3
            if (FUNC != FN_BOTH) begin : g_chk_fixed
                AST_MODE_IGNORED: assert property (@(posedge clk) disable iff (rst)
                    ($stable(a_in) && $stable(b_in) && !$stable(sub_in)) |-> ($stable(sum_out) && $stable(carry_out))); // R5
            end
        end else begin : g_chk_reg
            AST_SUM_LATE: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> sum_out == $past(ref_sum)); // R7
            AST_CARRY_LATE: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> carry_out == $past(ref_carry)); // R2
            AST_OVF_LATE: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> ovf_out == $past(ref_ovf)); // R3
            if (PIPE == PIPE_OUT) begin : g_chk_rst
                AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
                    $past(rst) |-> (sum_out == '0 && !carry_out && !ovf_out)); // R8
            end
        end
    endgenerate

endmodule

// File: tb/addsub_core_tb.sv
module addsub_core_tb;
    import addsub_pkg::*;

    timeunit 1ns;
    timeprecision 1ps;

    localparam int W  = 6;
    localparam int S  = 4;
    localparam int ND = 8;
    localparam int M  = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a   = '0;
    logic [W-1:0] b   = '0;
    logic         mode = 1'b0;

    logic [W-1:0] so [ND];
    logic         co [ND];
    logic         vo [ND];

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    // 0: lookahead, combinational, selectable
    addsub_core #(.WIDTH(W), .STAGE(S), .ARCH(ARCH_LOOKAHEAD), .FUNC(FN_BOTH), .PIPE(PIPE_NONE)) u_dut (
        .clk(clk), .rst(rst), .a_in(a), .b_in(b), .sub_in(mode),
        .sum_out(so[0]), .carry_out(co[0]), .ovf_out(vo[0]));
    addsub_core #(.WIDTH(W), .STAGE(S), .ARCH(ARCH_RIPPLE), .FUNC(FN_BOTH), .PIPE(PIPE_NONE)) u_dut_rip (
        .clk(clk), .rst(rst), .a_in(a), .b_in(b), .sub_in(mode),
        .sum_out(so[1]), .carry_out(co[1]), .ovf_out(vo[1]));
    addsub_core #(.WIDTH(W), .STAGE(S), .ARCH(ARCH_SELECT), .FUNC(FN_BOTH), .PIPE(PIPE_NONE)) u_dut_sel (
        .clk(clk), .rst(rst), .a_in(a), .b_in(b), .sub_in(mode),
        .sum_out(so[2]), .carry_out(co[2]), .ovf_out(vo[2]));
    addsub_core #(.WIDTH(W), .STAGE(S), .ARCH(ARCH_BYPASS), .FUNC(FN_BOTH), .PIPE(PIPE_NONE)) u_dut_byp (
        .clk(clk), .rst(rst), .a_in(a), .b_in(b), .sub_in(mode),
        .sum_out(so[3]), .carry_out(co[3]), .ovf_out(vo[3]));
    addsub_core #(.WIDTH(W), .STAGE(S), .ARCH(ARCH_LOOKAHEAD), .FUNC(FN_BOTH), .PIPE(PIPE_IN)) u_dut_inr (
        .clk(clk), .rst(rst), .a_in(a), .b_in(b), .sub_in(mode),
        .sum_out(so[4]), .carry_out(co[4]), .ovf_out(vo[4]));
    addsub_core #(.WIDTH(W), .STAGE(S), .ARCH(ARCH_BYPASS), .FUNC(FN_BOTH), .PIPE(PIPE_OUT)) u_dut_outr (
        .clk(clk), .rst(rst), .a_in(a), .b_in(b), .sub_in(mode),
        .sum_out(so[5]), .carry_out(co[5]), .ovf_out(vo[5]));
    addsub_core #(.WIDTH(W), .STAGE(S), .ARCH(ARCH_SELECT), .FUNC(FN_ADD), .PIPE(PIPE_NONE)) u_dut_add (
        .clk(clk), .rst(rst), .a_in(a), .b_in(b), .sub_in(mode),
        .sum_out(so[6]), .carry_out(co[6]), .ovf_out(vo[6]));
    addsub_core #(.WIDTH(W), .STAGE(S), .ARCH(ARCH_BYPASS), .FUNC(FN_SUB), .PIPE(PIPE_OUT)) u_dut_sub (
        .clk(clk), .rst(rst), .a_in(a), .b_in(b), .sub_in(mode),
        .sum_out(so[7]), .carry_out(co[7]), .ovf_out(vo[7]));

    // Expected result from plain integer arithmetic
    task automatic calc(input int x, input int y, input bit sub,
                        output logic [W-1:0] es, output bit ec, output bit eo);
        int r;
        int sx;
        int sy;
        int sr;
        sx = (x >= M / 2) ? x - M : x;
        sy = (y >= M / 2) ? y - M : y;
        if (sub) begin
            r  = x - y;
            ec = (x >= y);
            sr = sx - sy;
        end else begin
            r  = x + y;
            ec = (r >= M);
            sr = sx + sy;
        end
        es = W'((r + M) % M);
        eo = (sr > M / 2 - 1) || (sr < -(M / 2));
    endtask

    task automatic chk(input string tag, input int idx,
                       input logic [W-1:0] es, input bit ec, input bit eo);
        checks++;
        if (so[idx] !== es || co[idx] !== ec || vo[idx] !== eo) begin
            errors++;
            $display("FAIL %s dut%0d a=%0d b=%0d sub=%0d got sum=%0d c=%0b v=%0b exp sum=%0d c=%0b v=%0b",
                     tag, idx, a, b, mode, so[idx], co[idx], vo[idx], es, ec, eo);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        logic [W-1:0] es;
        logic [W-1:0] es_add;
        logic [W-1:0] es_sub;
        logic [W-1:0] ps;
        bit ec, eo, ec_add, eo_add, ec_sub, eo_sub, pc, po;

        // R8: reset with non-zero operands on the inputs
        a = 6'd37; b = 6'd21; mode = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 input-register reset", 4, '0, 1'b0, 1'b0);
        chk("R8 output-register reset", 5, '0, 1'b0, 1'b0);
        chk("R8 sub-only output-register reset", 7, '0, 1'b0, 1'b0);

        rst = 1'b0;
        ps = '0; pc = 1'b0; po = 1'b0;
        for (int ai = 0; ai < M; ai++) begin
            for (int bi = 0; bi < M; bi++) begin
                for (int m = 0; m < 2; m++) begin
                    a = W'(ai); b = W'(bi); mode = m[0];
                    calc(ai, bi, m[0], es, ec, eo);
                    calc(ai, bi, 1'b0, es_add, ec_add, eo_add);
                    calc(ai, bi, 1'b1, es_sub, ec_sub, eo_sub);
                    #1;
                    // Combinational cores settle without a clock edge
                    chk("R1/R2/R3/R4/R6 lookahead", 0, es, ec, eo);
                    chk("R1/R2/R3/R6 ripple", 1, es, ec, eo);
                    chk("R1/R2/R3/R9 select", 2, es, ec, eo);
                    chk("R1/R2/R3/R9 bypass", 3, es, ec, eo);
                    chk("R5 add-only ignores mode", 6, es_add, ec_add, eo_add);
                    // Output-registered core still holds the previous capture
                    chk("R7 hold before edge", 5, ps, pc, po);
                    @(posedge clk);
                    @(negedge clk);
                    chk("R7 input-register latency", 4, es, ec, eo);
                    chk("R7 output-register latency", 5, es, ec, eo);
                    chk("R5 sub-only ignores mode", 7, es_sub, ec_sub, eo_sub);
                    ps = es; pc = ec; po = eo;
                end
            end
        end

        // R8: reset asserted mid-run
        a = 6'd63; b = 6'd1; mode = 1'b0; rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R8 mid-run reset output-register", 5, '0, 1'b0, 1'b0);
        chk("R8 mid-run reset input-register", 4, '0, 1'b0, 1'b0);
        rst = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule